// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block sits between an analog-to-digital converter and the register that holds its results. Whenever the converter presents a finished result, the block tests it against one or two programmable thresholds and decides whether the result is kept or thrown away. A kept result is latched into the result register, raises a one-cycle accept strobe and sets a completion flag. That flag stays set until software reads the result.

The threshold test is chosen by a compare-enable bit and two mode bits. The greater-or-equal select bit picks between strict tests and inclusive tests. The range-enable bit picks between a single threshold and a two-value window. In window mode, the order of the two thresholds decides the kind of window. If threshold A is greater than threshold B, only results inside the window are kept. Otherwise only results outside it are kept. All values are unsigned 16-bit quantities. When compare is disabled, every result is kept.

Top module: `adc_wcmp`

## Requirements
- R1: During and directly after reset, `acc_o`, `done_o` and `data_o` are all zero.
- R2: With `cmp_en_i` = 0, every cycle with `res_valid_i` = 1 is accepted, whatever the thresholds and mode bits are.
- R3: With compare on, `range_en_i` = 0 and `ge_sel_i` = 0, a result is accepted only when it is strictly below `thr_a_i`. `thr_b_i` is ignored.
- R4: With compare on, `range_en_i` = 0 and `ge_sel_i` = 1, a result is accepted only when it is greater than or equal to `thr_a_i`. `thr_b_i` is ignored.
- R5: With compare on, `range_en_i` = 1 and `thr_a_i` <= `thr_b_i`, the outside-window test applies. When `ge_sel_i` = 0, a result is accepted when result < A or result > B. When `ge_sel_i` = 1, it is accepted when result <= A or result >= B.
- R6: With compare on, `range_en_i` = 1 and `thr_a_i` > `thr_b_i`, the inside-window test applies. When `ge_sel_i` = 0, a result is accepted when B < result < A. When `ge_sel_i` = 1, it is accepted when B <= result <= A.
- R7: On an accepted result, the following happens in the clock cycle after the one where `res_valid_i` was sampled. `acc_o` is high for exactly that one cycle, `data_o` equals the accepted result, and `done_o` is 1.
- R8: A rejected result, or a cycle without `res_valid_i`, raises no `acc_o`. It also leaves `data_o` unchanged and does not set `done_o`.
- R9: `rd_i` clears `done_o` on the next cycle. If an accepted result arrives in the same cycle as `rd_i`, the accept wins and `done_o` stays 1.
- R10: All comparisons are unsigned. For example, a result of 0x8000 is above a threshold of 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Finished-conversion strobe |
| res_data_i | input | 16 | Conversion result |
| thr_a_i | input | 16 | First threshold |
| thr_b_i | input | 16 | Second threshold, used only in window mode |
| cmp_en_i | input | 1 | 1 enables the threshold test |
| ge_sel_i | input | 1 | 0 selects strict tests, 1 selects inclusive tests |
| range_en_i | input | 1 | 1 selects the two-threshold window |
| rd_i | input | 1 | Result read strobe, clears the completion flag |
| acc_o | output | 1 | One-cycle strobe for an accepted result |
| data_o | output | 16 | Last accepted result |
| done_o | output | 1 | Completion flag |

## Verification
The random stimulus draws results equal to each threshold and one step either side of it. This exposes a design that swaps strict and inclusive bounds, because such a design keeps or drops exactly those end-point results wrongly. Directed cases use equal thresholds in window mode and values near 0x8000. A design that gets the window order wrong, or compares as signed, would accept the wrong side of the window. Further directed cases place a read in the same cycle as an accept. A design that gives the read priority would drop the flag. Rejected results that arrive after a kept one catch a design that overwrites the stored data.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;
  typedef enum logic [1:0] {
    WMODE_SINGLE_LT = 2'd0,
    WMODE_SINGLE_GE = 2'd1,
    WMODE_OUTSIDE   = 2'd2,
    WMODE_INSIDE    = 2'd3
  } wmode_e;
endpackage

// File: rtl/adc_wcmp_eval.sv
module adc_wcmp_eval
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] thr_a_i,
  input  logic [DW-1:0] thr_b_i,
  input  logic          cmp_en_i,
  input  logic          ge_sel_i,
  input  logic          range_en_i,
  output logic          pass_o
);
  // magnitude relations, all unsigned
  logic   res_lt_a, res_gt_a, res_lt_b, res_gt_b, a_gt_b;
  wmode_e mode;
  logic   hit;

  always_comb begin
    res_lt_a = res_i < thr_a_i;
    res_gt_a = res_i > thr_a_i;
    res_lt_b = res_i < thr_b_i;
    res_gt_b = res_i > thr_b_i;
    a_gt_b   = thr_a_i > thr_b_i;
  end

  always_comb begin
    if (!range_en_i)  mode = ge_sel_i ? WMODE_SINGLE_GE : WMODE_SINGLE_LT;
    else if (a_gt_b)  mode = WMODE_INSIDE;
    else              mode = WMODE_OUTSIDE;
  end

  always_comb begin
    unique case (mode)
      WMODE_SINGLE_LT: hit = res_lt_a;
      WMODE_SINGLE_GE: hit = !res_lt_a;
      WMODE_OUTSIDE:   hit = ge_sel_i ? (!res_gt_a || !res_lt_b)
                                      : (res_lt_a || res_gt_b);
      WMODE_INSIDE:    hit = ge_sel_i ? (!res_lt_b && !res_gt_a)
                                      : (res_gt_b && res_lt_a);
      default:         hit = 1'b0;
    endcase
    pass_o = cmp_en_i ? hit : 1'b1;
  end
endmodule

// File: rtl/adc_wcmp_store.sv
module adc_wcmp_store #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [DW-1:0] res_i,
  input  logic          rd_i,
  output logic          acc_o,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic          acc_q, acc_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic          done_q, done_d;

  // next state
  always_comb begin
    acc_d   = take_i;
    data_en = take_i;
    data_d  = res_i;
    // an accept in the same cycle as a read keeps the flag set
    done_d  = take_i | (done_q & ~rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign acc_o  = acc_q;
  assign data_o = data_q;
  assign done_o = done_q;
endmodule

// File: rtl/adc_wcmp.sv
module adc_wcmp #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_data_i,
  input  logic [DW-1:0] thr_a_i,
  input  logic [DW-1:0] thr_b_i,
  input  logic          cmp_en_i,
  input  logic          ge_sel_i,
  input  logic          range_en_i,
  input  logic          rd_i,
  output logic          acc_o,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic pass;
  logic take;

  adc_wcmp_eval #(.DW(DW)) u_eval (
    .res_i      (res_data_i),
    .thr_a_i    (thr_a_i),
    .thr_b_i    (thr_b_i),
    .cmp_en_i   (cmp_en_i),
    .ge_sel_i   (ge_sel_i),
    .range_en_i (range_en_i),
    .pass_o     (pass)
  );

  assign take = res_valid_i & pass;

  adc_wcmp_store #(.DW(DW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .res_i  (res_data_i),
    .rd_i   (rd_i),
    .acc_o  (acc_o),
    .data_o (data_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/adc_wcmp_chk.sv
module adc_wcmp_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          res_valid_i,
  input logic [DW-1:0] res_data_i,
  input logic [DW-1:0] thr_a_i,
  input logic          cmp_en_i,
  input logic          ge_sel_i,
  input logic          range_en_i,
  input logic          rd_i,
  input logic          acc_o,
  input logic [DW-1:0] data_o,
  input logic          done_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!acc_o && !done_o && data_o == '0);
    end
  end

  p_bypass_accepts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !cmp_en_i) |=> acc_o);

  p_single_lt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && cmp_en_i && !range_en_i && !ge_sel_i) |=>
      (acc_o == ($past(res_data_i) < $past(thr_a_i))));

  p_single_ge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && cmp_en_i && !range_en_i && ge_sel_i) |=>
      (acc_o == ($past(res_data_i) >= $past(thr_a_i))));

  p_accept_sets_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> done_o);

  p_accept_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> (!acc_o || data_o == $past(res_data_i)));

  p_idle_no_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !acc_o);

  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_o |-> $stable(data_o));

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !res_valid_i) |=> !done_o);
endmodule

bind adc_wcmp adc_wcmp_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_data_i  (res_data_i),
  .thr_a_i     (thr_a_i),
  .cmp_en_i    (cmp_en_i),
  .ge_sel_i    (ge_sel_i),
  .range_en_i  (range_en_i),
  .rd_i        (rd_i),
  .acc_o       (acc_o),
  .data_o      (data_o),
  .done_o      (done_o)
);

// File: tb/tb_adc_wcmp.sv
`timescale 1ns/1ps
module tb_adc_wcmp;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid;
  logic [DW-1:0] res, ta, tb;
  logic          cen, ge, rng, rd;
  logic          acc;
  logic [DW-1:0] data;
  logic          done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] m_data;
  logic          m_done;

  always #2 clk = ~clk;

  adc_wcmp #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(res),
    .thr_a_i(ta), .thr_b_i(tb), .cmp_en_i(cen), .ge_sel_i(ge),
    .range_en_i(rng), .rd_i(rd), .acc_o(acc), .data_o(data), .done_o(done)
  );

  function automatic bit exp_pass(input logic [DW-1:0] r, a, b,
                                  input bit en, g, w);
    if (!en) return 1'b1;
    if (!w)  return g ? (r >= a) : (r < a);
    if (a <= b) return g ? (r <= a || r >= b) : (r < a || r > b);
    return g ? (r >= b && r <= a) : (r > b && r < a);
  endfunction

  function automatic string mode_tag(input bit en, g, w,
                                     input logic [DW-1:0] a, b);
    if (!en) return "R2";
    if (!w)  return g ? "R4" : "R3";
    return (a <= b) ? "R5" : "R6";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // drive one cycle at a falling edge, check one cycle later at the next falling edge
  task automatic step(input bit v, input logic [DW-1:0] r, a, b,
                      input bit en, g, w, input bit rdv);
    bit p;
    valid = v; res = r; ta = a; tb = b; cen = en; ge = g; rng = w; rd = rdv;
    p = v && exp_pass(r, a, b, en, g, w);
    if (p) m_data = r;
    m_done = p | (m_done & ~rdv);
    @(posedge clk);
    @(negedge clk);
    chk(v ? mode_tag(en, g, w, a, b) : "R8", {15'd0, acc}, {15'd0, p});
    chk(p ? "R7" : "R8", data, m_data);
    chk(rdv ? "R9" : "R7", {15'd0, done}, {15'd0, m_done});
    valid = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; valid = 0; res = 0; ta = 0; tb = 0;
    cen = 0; ge = 0; rng = 0; rd = 0;
    m_data = '0; m_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {15'd0, acc}, 16'd0);
    chk("R1", data, 16'd0);
    chk("R1", {15'd0, done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {14'd0, acc, done}, 16'd0);

    // directed corners
    step(1, 16'h0100, 16'h0100, 16'h0000, 1, 0, 0, 0); // R3 equal rejected
    step(1, 16'h0100, 16'h0100, 16'h0000, 1, 1, 0, 0); // R4 equal accepted
    step(1, 16'h00FF, 16'h0100, 16'h0000, 1, 1, 0, 0); // R8 reject keeps data
    step(1, 16'h8000, 16'h7FFF, 16'h0000, 1, 1, 0, 0); // R10 unsigned
    step(1, 16'h8000, 16'h7FFF, 16'h0000, 1, 0, 0, 0); // R10 not below
    step(1, 16'h0200, 16'h0200, 16'h0200, 1, 0, 1, 0); // R5 equal bounds strict
    step(1, 16'h0200, 16'h0200, 16'h0200, 1, 1, 1, 0); // R5 equal bounds incl
    step(1, 16'h0300, 16'h0400, 16'h0300, 1, 0, 1, 0); // R6 lower end strict
    step(1, 16'h0300, 16'h0400, 16'h0300, 1, 1, 1, 0); // R6 lower end incl
    step(1, 16'hFFFF, 16'hFFFF, 16'h0000, 1, 1, 1, 0); // R6 top
    step(0, 16'h0000, 16'h0000, 16'h0000, 0, 0, 0, 1); // R9 read clears
    step(1, 16'h0055, 16'h0000, 16'h0000, 0, 0, 0, 0); // R2 bypass
    step(1, 16'h0066, 16'h0000, 16'h0000, 0, 0, 0, 1); // R9 accept wins
    step(1, 16'h0010, 16'h0000, 16'h0000, 1, 0, 0, 1); // R9 reject + read clears

    // random stimulus with end-point biased results
    for (int i = 0; i < 2000; i++) begin
      logic [DW-1:0] a, b, r;
      int sel;
      a = DW'($urandom);
      b = ($urandom_range(0, 3) == 0) ? a : DW'($urandom);
      sel = $urandom_range(0, 6);
      case (sel)
        0: r = a;
        1: r = a + 16'd1;
        2: r = a - 16'd1;
        3: r = b;
        4: r = b + 16'd1;
        5: r = b - 16'd1;
        default: r = DW'($urandom);
      endcase
      step($urandom_range(0, 4) != 0, r, a, b,
           $urandom_range(0, 5) != 0, 1'($urandom), 1'($urandom),
           $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule